// File: doc/BRIEF.md
# Framed Serial Shift Channel

A single shift-register channel that is paced by an external timer. The timer supplies a shift clock, which the channel samples and edge-detects in the system clock domain, and a one-cycle expiry strobe that marks the end of a word. The same datapath serves four functions, chosen by a 3-bit mode input: a receiver that copies the shifter into a buffer on expiry, a transmitter that moves the buffer into the shifter, a pattern matcher that compares on expiry, and a pattern matcher that compares on every cycle.

Frames may carry an optional start bit and an optional stop bit. The transmitter drives these bits and the receiver and matchers check them, raising a sticky error flag on a mismatch. Serial input comes either from a pin or from a neighbouring channel's output. The serial output goes to a pin driver with a selectable polarity and four drive styles. The buffer, a status flag and the error flag are plain ports, so an outer register block can wrap them.

Top module: `fsh_channel`

## Requirements
- R1: The supported mode codes are 000 off, 001 receive, 010 transmit, 100 match-on-expiry and 101 match-continuous. Any other code behaves as off: the shifter holds, expiry captures nothing and no flag is set. The buffer can still be written.
- R2: Data moves least significant bit first. On each qualifying shift-clock edge during the data phase, the shifter shifts right by one and takes the serial input into its top bit. The transmitted bit is shifter bit 0.
- R3: In receive mode an expiry strobe copies the shifter into the buffer and sets the status flag.
- R4: In transmit mode a load copies the buffer into the shifter and sets the status flag. With no stop bit configured, an expiry begins the next word at once.
- R5: In match-on-expiry mode an expiry sets the status flag only if shifter bits [15:0] equal buffer bits [15:0] at every position where the mask in buffer bits [31:16] is 0 (a mask bit of 1 ignores that position). Between expiries the flag is not set.
- R6: In match-continuous mode the status flag is the masked comparison of R5 from the previous cycle, refreshed on every cycle.
- R7: The transmit start field sets how a word begins. 00 loads as soon as the word begins (on entry to the mode, or on expiry). 01 loads on the first shift edge. 10 or 11 first drives a start bit equal to the field's bit 0, then loads on the first shift edge.
- R8: With a start field of 10 or 11 in receive or match modes, the first shift edge of a word samples the start bit. If it differs from the field's bit 0, the error flag is set.
- R9: A stop field of 10 or 11 enters a stop phase on expiry. In transmit, the stop phase drives the field's bit 0. In receive or match modes, the next shift edge samples the stop bit and sets the error flag if the sample differs from the field's bit 0. Codes 00 and 01 mean no stop bit.
- R10: With the edge select at 0, shifting happens on rising shift-clock edges; with it at 1, on falling edges. Edges of the other direction do nothing.
- R11: Input select 0 takes serial data from the pin input; input select 1 takes it from the neighbour input.
- R12: The output bit is inverted when pin polarity is 1. Drive style 00 gives enable 0 and data 0. Style 01 gives data 0 and enable high only when the bit is 0 (open drain). Style 10 gives data equal to the bit with enable 0. Style 11 gives data equal to the bit with enable 1.
- R13: Reset clears the buffer, shifter and both flags. The status flag clears on a buffer read or write strobe, and a set in the same cycle wins. The error flag clears when the clear input is 1 and no new error occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Channel function code |
| start_cfg_i | input | 2 | Start-bit field |
| stop_cfg_i | input | 2 | Stop-bit field |
| in_src_i | input | 1 | Serial input select: 0 pin, 1 neighbour |
| clk_pol_i | input | 1 | Shift edge select: 0 rising, 1 falling |
| pin_pol_i | input | 1 | Output pin inversion |
| pin_cfg_i | input | 2 | Output drive style |
| shift_clk_i | input | 1 | Shift clock from the timer |
| expiry_i | input | 1 | Timer expiry strobe |
| pin_in_i | input | 1 | Serial data from the pin |
| chain_in_i | input | 1 | Serial data from the neighbour channel |
| buf_wr_i | input | 1 | Buffer write strobe |
| buf_wdata_i | input | 32 | Buffer write data |
| buf_rd_i | input | 1 | Buffer read strobe |
| err_clr_i | input | 1 | Error flag clear |
| buf_o | output | 32 | Buffer contents |
| status_o | output | 1 | Status flag |
| error_o | output | 1 | Framing error flag |
| pin_out_o | output | 1 | Pin output data |
| pin_oe_o | output | 1 | Pin output enable |
| chain_out_o | output | 1 | Shifter bit 0 to the neighbour channel |

## Verification
A shift-clock transition applied between clock edges acts at the next rising system-clock edge. The shifter, the buffer capture, the load, the status flag and the error flag therefore all show their new values one cycle later. The continuous-match flag is registered from the comparator, so it follows the final shift by two edges. The pin outputs are combinational from the shifter and phase, so they change in the same cycle as the shifter. Every stimulus task ends on a falling clock edge, and the scoreboard compares the queued expectations at that point, which is exactly the cycle in which each result is due.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  localparam logic [2:0] FSH_OFF   = 3'b000;
  localparam logic [2:0] FSH_RX    = 3'b001;
  localparam logic [2:0] FSH_TX    = 3'b010;
  localparam logic [2:0] FSH_MSTO  = 3'b100;
  localparam logic [2:0] FSH_MCONT = 3'b101;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_START = 2'd1,
    PH_ARM   = 2'd2,
    PH_STOP  = 2'd3
  } fsh_phase_e;

  function automatic logic fsh_mode_active(input logic [2:0] m);
    return (m == FSH_RX) || (m == FSH_TX) || (m == FSH_MSTO) || (m == FSH_MCONT);
  endfunction

  // Phase a new word begins in, from the start field
  function automatic fsh_phase_e fsh_entry_phase(input logic is_tx, input logic [1:0] st);
    if (st[1])                     return PH_START;
    else if (is_tx && st == 2'b01) return PH_ARM;
    else                           return PH_DATA;
  endfunction

  // Transmitter loads immediately when a word begins
  function automatic logic fsh_entry_loads(input logic is_tx, input logic [1:0] st);
    return is_tx && (st == 2'b00);
  endfunction

  // Returns {oe, data} for a drive style and a logical bit
  function automatic logic [1:0] fsh_pin_drive(input logic [1:0] cfg, input logic d);
    case (cfg)
      2'b01:   return {~d, 1'b0};
      2'b10:   return {1'b0, d};
      2'b11:   return {1'b1, d};
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fsh_edge_det.sv
module fsh_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  logic rise_w, fall_w;
  assign rise_w = ~sig_q & sig_i;
  assign fall_w = sig_q & ~sig_i;
  assign evt_o  = fall_sel_i ? fall_w : rise_w;
endmodule

// File: rtl/fsh_frame_ctrl.sv
module fsh_frame_ctrl
  import fsh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       is_tx_i,
  input  logic       enter_i,
  input  logic       expiry_i,
  input  logic       shift_evt_i,
  input  logic [1:0] start_cfg_i,
  input  logic [1:0] stop_cfg_i,
  input  logic       in_bit_i,
  output fsh_phase_e phase_o,
  output logic       do_shift_o,
  output logic       do_load_o,
  output logic       exp_act_o,
  output logic       start_err_o,
  output logic       stop_err_o
);
  fsh_phase_e phase_q, phase_n;
  logic sh_act, stop_on;

  assign exp_act_o = active_i & expiry_i;
  assign sh_act    = active_i & shift_evt_i & ~expiry_i & ~enter_i;
  assign stop_on   = stop_cfg_i[1];

  always_comb begin
    phase_n     = phase_q;
    do_shift_o  = 1'b0;
    do_load_o   = 1'b0;
    start_err_o = 1'b0;
    stop_err_o  = 1'b0;
    if (!active_i) begin
      phase_n = PH_DATA;
    end else if (enter_i) begin
      phase_n   = fsh_entry_phase(is_tx_i, start_cfg_i);
      do_load_o = fsh_entry_loads(is_tx_i, start_cfg_i);
    end else if (exp_act_o) begin
      if (stop_on) begin
        phase_n = PH_STOP;
      end else begin
        phase_n   = fsh_entry_phase(is_tx_i, start_cfg_i);
        do_load_o = fsh_entry_loads(is_tx_i, start_cfg_i);
      end
    end else if (sh_act) begin
      case (phase_q)
        PH_START: begin
          phase_n = PH_DATA;
          if (is_tx_i) do_load_o = 1'b1;
          else         start_err_o = (in_bit_i != start_cfg_i[0]);
        end
        PH_ARM: begin
          phase_n   = PH_DATA;
          do_load_o = 1'b1;
        end
        PH_STOP: begin
          if (!is_tx_i) stop_err_o = (in_bit_i != stop_cfg_i[0]);
          phase_n   = fsh_entry_phase(is_tx_i, start_cfg_i);
          do_load_o = fsh_entry_loads(is_tx_i, start_cfg_i);
        end
        default: do_shift_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_DATA;
    else        phase_q <= phase_n;
  end

  assign phase_o = phase_q;

  // A shift edge in the start phase always leads into the data phase
  assert_start_to_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !enter_i && !expiry_i && shift_evt_i && phase_q == PH_START)
      |=> (phase_q == PH_DATA));
endmodule

// File: rtl/fsh_pin_drv.sv
module fsh_pin_drv
  import fsh_pkg::*;
(
  input  logic       bit_i,
  input  logic       pol_i,
  input  logic [1:0] cfg_i,
  output logic       pin_o,
  output logic       oe_o
);
  logic [1:0] drv;
  assign drv   = fsh_pin_drive(cfg_i, bit_i ^ pol_i);
  assign oe_o  = drv[1];
  assign pin_o = drv[0];
endmodule

// File: rtl/fsh_channel.sv
module fsh_channel
  import fsh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        start_cfg_i,
  input  logic [1:0]        stop_cfg_i,
  input  logic              in_src_i,
  input  logic              clk_pol_i,
  input  logic              pin_pol_i,
  input  logic [1:0]        pin_cfg_i,
  input  logic              shift_clk_i,
  input  logic              expiry_i,
  input  logic              pin_in_i,
  input  logic              chain_in_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              status_o,
  output logic              error_o,
  output logic              pin_out_o,
  output logic              pin_oe_o,
  output logic              chain_out_o
);
  localparam int HALF = DATA_W / 2;

  // Masked compare: upper half of the buffer masks the lower half
  function automatic logic masked_eq(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] b);
    return ((s[HALF-1:0] ^ b[HALF-1:0]) & ~b[DATA_W-1:HALF]) == '0;
  endfunction

  logic [DATA_W-1:0] sr_q, buf_q;
  logic [2:0]        mode_q;
  logic              active, enter, is_tx, in_bit;
  logic              shift_evt, do_shift, do_load, exp_act, start_err, stop_err;
  logic              capture, match_now, status_set, err_set, access, tx_bit;
  fsh_phase_e        phase;

  assign active = fsh_mode_active(mode_i);
  assign enter  = active && (mode_i != mode_q);
  assign is_tx  = (mode_i == FSH_TX);
  assign in_bit = in_src_i ? chain_in_i : pin_in_i;

  fsh_edge_det u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_i      (shift_clk_i),
    .fall_sel_i (clk_pol_i),
    .evt_o      (shift_evt)
  );

  fsh_frame_ctrl u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .is_tx_i     (is_tx),
    .enter_i     (enter),
    .expiry_i    (expiry_i),
    .shift_evt_i (shift_evt),
    .start_cfg_i (start_cfg_i),
    .stop_cfg_i  (stop_cfg_i),
    .in_bit_i    (in_bit),
    .phase_o     (phase),
    .do_shift_o  (do_shift),
    .do_load_o   (do_load),
    .exp_act_o   (exp_act),
    .start_err_o (start_err),
    .stop_err_o  (stop_err)
  );

  assign capture    = exp_act && (mode_i == FSH_RX);
  assign match_now  = masked_eq(sr_q, buf_q);
  assign status_set = capture || do_load || (exp_act && (mode_i == FSH_MSTO) && match_now);
  assign err_set    = start_err | stop_err;
  assign access     = buf_wr_i | buf_rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= FSH_OFF;
      sr_q     <= '0;
      buf_q    <= '0;
      status_o <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (do_load)       sr_q <= buf_q;
      else if (do_shift) sr_q <= {in_bit, sr_q[DATA_W-1:1]};
      if (capture)       buf_q <= sr_q;
      else if (buf_wr_i) buf_q <= buf_wdata_i;
      if (mode_i == FSH_MCONT) status_o <= match_now;
      else                     status_o <= status_set | (status_o & ~access);
      error_o <= err_set | (error_o & ~err_clr_i);
    end
  end

  always_comb begin
    tx_bit = sr_q[0];
    if (is_tx && phase == PH_START)     tx_bit = start_cfg_i[0];
    else if (is_tx && phase == PH_STOP) tx_bit = stop_cfg_i[0];
  end

  fsh_pin_drv u_pin (
    .bit_i (tx_bit),
    .pol_i (pin_pol_i),
    .cfg_i (pin_cfg_i),
    .pin_o (pin_out_o),
    .oe_o  (pin_oe_o)
  );

  assign buf_o       = buf_q;
  assign chain_out_o = sr_q[0];

  assert_off_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(sr_q));

  assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> (sr_q == {$past(in_bit), $past(sr_q[DATA_W-1:1])}));

  assert_rx_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (buf_q == $past(sr_q)) && status_o);

  assert_tx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (sr_q == $past(buf_q)) && status_o);

  assert_cont_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == FSH_MCONT) |=> (status_o == $past(match_now)));

  assert_err_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !start_err && !stop_err) |=> !error_o);
endmodule

// File: tb/fsh_channel_tb.sv
module fsh_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [1:0]  start_cfg = 2'b00, stop_cfg = 2'b00, pin_cfg = 2'b00;
  logic        in_src = 1'b0, clk_pol = 1'b0, pin_pol = 1'b0;
  logic        sclk = 1'b0, expiry = 1'b0, pin_in = 1'b0, chain_in = 1'b0;
  logic        buf_wr = 1'b0, buf_rd = 1'b0, err_clr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] buf_o;
  logic        status, error, pin_out, pin_oe, chain_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsh_channel #(.DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .start_cfg_i(start_cfg),
    .stop_cfg_i(stop_cfg), .in_src_i(in_src), .clk_pol_i(clk_pol),
    .pin_pol_i(pin_pol), .pin_cfg_i(pin_cfg), .shift_clk_i(sclk),
    .expiry_i(expiry), .pin_in_i(pin_in), .chain_in_i(chain_in),
    .buf_wr_i(buf_wr), .buf_wdata_i(wdata), .buf_rd_i(buf_rd),
    .err_clr_i(err_clr), .buf_o(buf_o), .status_o(status), .error_o(error),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .chain_out_o(chain_out)
  );

  // Scoreboard: sel 0 buf, 1 status, 2 error, 3 pin_out, 4 pin_oe, 5 chain_out
  typedef struct { string req; int sel; logic [31:0] exp; } item_t;
  item_t sb_q[$];

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return buf_o;
      1: return {31'd0, status};
      2: return {31'd0, error};
      3: return {31'd0, pin_out};
      4: return {31'd0, pin_oe};
      default: return {31'd0, chain_out};
    endcase
  endfunction

  task automatic expect_val(string req, int sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic monitor_drain();
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  endtask

  task automatic chk(string req, int sel, logic [31:0] exp);
    expect_val(req, sel, exp);
    monitor_drain();
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic go_mode(logic [2:0] m);
    mode = 3'b000; tick();
    mode = m; tick();
  endtask

  task automatic drive_in(logic b);
    if (in_src) begin chain_in = b; pin_in = ~b; end
    else        begin pin_in = b;  chain_in = ~b; end
  endtask

  // Bit b is presented only around the selected edge; the other edge sees ~b
  task automatic bit_cycle(logic b);
    drive_in(clk_pol ? ~b : b); sclk = 1'b1; tick();
    drive_in(clk_pol ? b : ~b); sclk = 1'b0; tick();
  endtask

  task automatic shift_word(logic [31:0] w);
    for (int i = 0; i < 32; i++) bit_cycle(w[i]);
  endtask

  task automatic expire();   expiry = 1'b1; tick(); expiry = 1'b0; endtask
  task automatic read_buf(); buf_rd = 1'b1; tick(); buf_rd = 1'b0; endtask
  task automatic clr_err();  err_clr = 1'b1; tick(); err_clr = 1'b0; endtask
  task automatic write_buf(logic [31:0] w);
    buf_wr = 1'b1; wdata = w; tick(); buf_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] t1;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    // R13 reset state
    chk("R13 reset buf", 0, 32'h0);
    chk("R13 reset status", 1, 0);
    chk("R13 reset error", 2, 0);
    chk("R13 reset shifter", 5, 0);
    chk("R12 style 00 oe", 4, 0);

    // R1 unsupported codes
    mode = 3'b011; tick();
    write_buf(32'hA5A5_0F0F);
    shift_word(32'hFFFF_FFFF);
    expire();
    chk("R1 no status", 1, 0);
    chk("R1 shifter held", 5, 0);
    chk("R1 no capture", 0, 32'hA5A5_0F0F);
    mode = 3'b111; tick(); bit_cycle(1'b1);
    chk("R1 code 111 held", 5, 0);

    // R3 / R2 receive from pin
    in_src = 1'b0;
    go_mode(3'b001);
    shift_word(32'h1234_ABCD);
    expire();
    chk("R3 R2 rx capture", 0, 32'h1234_ABCD);
    chk("R3 rx status", 1, 1);
    read_buf();
    chk("R13 status read clear", 1, 0);

    // R11 neighbour input
    in_src = 1'b1;
    shift_word(32'hDEAD_6001);
    expire();
    chk("R11 chain source", 0, 32'hDEAD_6001);
    read_buf();

    // R10 falling-edge shifting
    in_src = 1'b0; clk_pol = 1'b1;
    shift_word(32'h0F1E_2D3C);
    expire();
    chk("R10 falling edge", 0, 32'h0F1E_2D3C);
    read_buf();
    clk_pol = 1'b0;

    // R4 / R7 transmit, start 00
    t1 = 32'hC3A5_5A3C;
    pin_cfg = 2'b11; pin_pol = 1'b0;
    write_buf(t1);
    go_mode(3'b010);
    chk("R4 R7 load on entry status", 1, 1);
    chk("R4 first bit", 3, {31'd0, t1[0]});
    chk("R12 style 11 oe", 4, 1);
    chk("R4 chain out", 5, {31'd0, t1[0]});
    for (int k = 1; k < 32; k++) begin
      bit_cycle(1'b0);
      chk("R2 tx lsb first", 3, {31'd0, t1[k]});
    end
    read_buf();

    // R7 / R9 / R12 framed transmit, inverted pin
    start_cfg = 2'b10; stop_cfg = 2'b11; pin_pol = 1'b1;
    write_buf(32'h8000_0001);
    go_mode(3'b010);
    chk("R7 start bit driven", 3, 1);
    chk("R7 no load before shift", 1, 0);
    bit_cycle(1'b0);
    chk("R12 inverted data", 3, 0);
    chk("R7 load on first shift", 1, 1);
    bit_cycle(1'b0);
    chk("R2 second bit", 3, 1);
    expire();
    chk("R9 stop bit driven", 3, 0);
    bit_cycle(1'b0);
    chk("R7 start after stop", 3, 1);

    // R7 start 01
    start_cfg = 2'b01; stop_cfg = 2'b00; pin_pol = 1'b0;
    read_buf();
    write_buf(32'h0000_0001);
    go_mode(3'b010);
    chk("R7 arm no load", 1, 0);
    bit_cycle(1'b0);
    chk("R7 arm load status", 1, 1);
    chk("R7 arm load data", 3, 1);

    // R12 drive styles with bit 1 then bit 0
    pin_cfg = 2'b00; tick();
    chk("R12 style 00 out", 3, 0);
    chk("R12 style 00 oe", 4, 0);
    pin_cfg = 2'b01; tick();
    chk("R12 open drain high oe", 4, 0);
    chk("R12 open drain out", 3, 0);
    pin_cfg = 2'b10; tick();
    chk("R12 style 10 out", 3, 1);
    chk("R12 style 10 oe", 4, 0);
    bit_cycle(1'b0);
    pin_cfg = 2'b01; tick();
    chk("R12 open drain low oe", 4, 1);
    pin_cfg = 2'b11;

    // R8 / R9 receive framing
    start_cfg = 2'b11; stop_cfg = 2'b10;
    go_mode(3'b001);
    bit_cycle(1'b0);
    chk("R8 bad start", 2, 1);
    clr_err();
    chk("R13 error clear", 2, 0);
    shift_word(32'h5555_AAAA);
    expire();
    chk("R3 framed capture", 0, 32'h5555_AAAA);
    bit_cycle(1'b1);
    chk("R9 bad stop", 2, 1);
    clr_err();
    bit_cycle(1'b1);
    chk("R8 good start", 2, 0);
    shift_word(32'h0BAD_F00D);
    expire();
    bit_cycle(1'b0);
    chk("R9 good stop", 2, 0);
    chk("R3 second frame", 0, 32'h0BAD_F00D);

    // R5 match on expiry
    start_cfg = 2'b00; stop_cfg = 2'b00;
    read_buf();
    go_mode(3'b100);
    write_buf(32'h00F0_1234);
    shift_word(32'h0000_12C4);
    chk("R5 no compare before expiry", 1, 0);
    expire();
    chk("R5 masked match", 1, 1);
    read_buf();
    shift_word(32'h0000_1334);
    expire();
    chk("R5 unmasked mismatch", 1, 0);

    // R6 continuous match
    go_mode(3'b101);
    shift_word(32'hFFFF_1234);
    chk("R6 continuous match", 1, 1);
    write_buf(32'h0000_4321);
    tick();
    chk("R6 continuous follows", 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule